// File: doc/BRIEF.md
# CPU Address Breakpoint Unit

This unit watches the address bus of a CPU and raises an active-high breakpoint output when the bus carries a programmed breakpoint address. The CPU sets up the unit through a small register port. Two byte registers hold the compare address, and a control register holds an enable bit, a mode bit and a sticky hit flag. The unit registers the bus once and compares the registered value with the programmed address.

In level mode the output is high in exactly those cycles where the registered address matches. In pulse mode each match starts a high pulse of a fixed number of CPU clocks (eight by default). A match that arrives while a pulse is running starts the count again. The pulse length is counted in clock cycles, so it stays the same whatever CPU clock rate is chosen. The hit flag records that an enabled match has happened. It stays set until the CPU writes a 1 to it.

Top module: `addr_brk_unit`

## Requirements
- R1: After reset `brk_out` is low and every register reads 0.
- R2: Register offset 0 holds address bits [7:0] and offset 1 holds bits [15:8]. Offset 2 is control: bit 0 enable, bit 1 pulse mode, bit 2 hit flag. Reads of offsets 0 and 1 and of control bits 0 and 1 return the last written value.
- R3: With enable set and pulse mode clear, `brk_out` is high in the cycle after a clock edge that sampled `cpu_addr` equal to the breakpoint address, and is low in the cycle after an edge that sampled any other address.
- R4: With enable clear, `brk_out` stays low whatever appears on `cpu_addr`.
- R5: With enable and pulse mode set, a single matching sample gives a `brk_out` high pulse of exactly 8 cycles. It starts in the same cycle in which level mode would go high.
- R6: In pulse mode, a match that comes during a running pulse restarts the count. The output then stays high until 8 cycles after the latest match, with no gap.
- R7: The hit flag (control bit 2) becomes 1 one cycle after an enabled match shows on the output. It does not set while enable is clear. Writing control with bit 2 = 1 clears it, writing bit 2 = 0 leaves it set, and a match in the same cycle as a clear keeps it set.
- R8: A write to a breakpoint address byte is used for comparison from the cycle after the write edge, including while a match is in progress.
- R9: A match that lasts several cycles keeps `brk_out` high without a break. In pulse mode the output stays high for 7 more cycles after the last matching cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset; the unit releases it synchronously inside |
| cpu_addr | input | 16 | CPU address bus being watched |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the register at `reg_addr` |
| brk_out | output | 1 | Active-high breakpoint indication |

## Verification
The hardest case to reach is a pulse retrigger, because a second match has to land at every possible distance into a running pulse. The bench places a second matching address from 1 to 9 cycles after the first. It compares the output every cycle against the distance from the latest match, so both the merged windows and the gap after them are checked. A second hard case is a set and a clear of the hit flag in the same cycle. The bench holds the bus on the breakpoint address while it writes the clear, which makes the two meet at the same edge.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int DATA_W      = 8;
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_PM_BIT = 1;
  localparam int CTRL_HIT_BIT = 2;

  typedef struct packed {
    logic en;
    logic pulse_mode;
    logic hit;
  } brk_ctrl_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int NBYTES = ADDR_W / DATA_W,
  localparam int REG_AW = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_hit,
  output logic [ADDR_W-1:0] bp_addr,
  output brk_ctrl_t         ctrl,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [REG_AW-1:0] CTRL_OFF = REG_AW'(NBYTES);

  logic [ADDR_W-1:0] bp_q, bp_d;
  brk_ctrl_t         ctrl_q, ctrl_d;
  logic              ctrl_wr;

  assign ctrl_wr = we && (addr == CTRL_OFF);

  always_comb begin
    bp_d = bp_q;
    for (int i = 0; i < NBYTES; i++) begin
      if (we && (addr == REG_AW'(i))) bp_d[i*DATA_W +: DATA_W] = wdata;
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.en         = wdata[CTRL_EN_BIT];
      ctrl_d.pulse_mode = wdata[CTRL_PM_BIT];
      if (wdata[CTRL_HIT_BIT]) ctrl_d.hit = 1'b0;
    end
    if (set_hit) ctrl_d.hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= '0;
      ctrl_q <= '0;
    end else begin
      bp_q   <= bp_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (addr == REG_AW'(i)) rdata = bp_q[i*DATA_W +: DATA_W];
    end
    if (addr == CTRL_OFF) begin
      rdata[CTRL_EN_BIT]  = ctrl_q.en;
      rdata[CTRL_PM_BIT]  = ctrl_q.pulse_mode;
      rdata[CTRL_HIT_BIT] = ctrl_q.hit;
    end
  end

  assign bp_addr = bp_q;
  assign ctrl    = ctrl_q;
endmodule

// File: rtl/brk_match.sv
module brk_match #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              en,
  output logic [ADDR_W-1:0] addr_q,
  output logic              match
);
  logic [ADDR_W-1:0] addr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_r <= '0;
    else        addr_r <= cpu_addr;
  end

  assign addr_q = addr_r;
  assign match  = en && (addr_r == bp_addr);
endmodule

// File: rtl/brk_pulse.sv
module brk_pulse #(
  parameter int PULSE_LEN = 8,
  localparam int CNT_W = $clog2(PULSE_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic pulse_mode,
  output logic brk
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_busy;

  assign cnt_busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!pulse_mode)   cnt_d = '0;
    else if (match)    cnt_d = CNT_W'(PULSE_LEN - 1);
    else if (cnt_busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign brk = match || (pulse_mode && cnt_busy);
endmodule

// File: rtl/addr_brk_unit.sv
module addr_brk_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PULSE_LEN = 8,
  parameter int SYNC_STG  = 2,
  localparam int REG_AW = $clog2(ADDR_W / DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              brk_out
);
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_n_int;
  logic [ADDR_W-1:0]   bp_addr;
  logic [ADDR_W-1:0]   addr_q;
  brk_ctrl_t           ctrl;
  logic                match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STG-1];

  brk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .set_hit (match),
    .bp_addr (bp_addr),
    .ctrl    (ctrl),
    .rdata   (reg_rdata)
  );

  brk_match #(.ADDR_W(ADDR_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cpu_addr (cpu_addr),
    .bp_addr  (bp_addr),
    .en       (ctrl.en),
    .addr_q   (addr_q),
    .match    (match)
  );

  brk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .match      (match),
    .pulse_mode (ctrl.pulse_mode),
    .brk        (brk_out)
  );
endmodule

// File: rtl/addr_brk_unit_chk.sv
module addr_brk_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              en,
  input logic              pulse_mode,
  input logic              hit,
  input logic              match,
  input logic              brk_out,
  input logic [ADDR_W-1:0] addr_q,
  input logic [ADDR_W-1:0] bp_addr
);
  always @(posedge clk) begin
    if (rst_ni === 1'b0) a_r1_reset_low: assert (!brk_out);
  end

  a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |-> !brk_out);

  a_r3_level_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    !pulse_mode |-> (brk_out == (en && (addr_q == bp_addr))));

  a_r9_match_drives_out: assert property (@(posedge clk) disable iff (!rst_ni)
    match |-> brk_out);

  a_r5_pulse_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (pulse_mode && $past(pulse_mode) && $past(match)) |-> brk_out);

  a_r7_hit_sets: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(match) |-> hit);
endmodule

bind addr_brk_unit addr_brk_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_n_int),
  .en         (ctrl.en),
  .pulse_mode (ctrl.pulse_mode),
  .hit        (ctrl.hit),
  .match      (match),
  .brk_out    (brk_out),
  .addr_q     (addr_q),
  .bp_addr    (bp_addr)
);

// File: tb/addr_brk_unit_bench.sv
module addr_brk_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        brk_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [15:0] bp;
  bit          m_en, m_pm;
  int          since;

  always #5 clk = ~clk;

  addr_brk_unit u_addr_brk_unit (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .brk_out(brk_out)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic set_bp(logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
    bp = v;
  endtask

  task automatic set_ctrl(bit en, bit pm, bit clr);
    wr(2'd2, {5'b0, clr, pm, en});
    m_en = en; m_pm = pm; since = 1000;
  endtask

  task automatic step(logic [15:0] a, string req);
    bit m;
    cpu_addr = a;
    m = m_en && (a == bp);
    if (m) since = 0;
    else if (since < 1000) since++;
    @(negedge clk);
    check(req, {15'b0, brk_out}, {15'b0, (m_pm ? (since <= 7) : m)});
  endtask

  task automatic read_chk(logic [1:0] a, logic [7:0] exp, string req);
    reg_addr = a;
    #1;
    check(req, {8'b0, reg_rdata}, {8'b0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h0;
    bp = 16'h0; m_en = 0; m_pm = 0; since = 1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 brk", {15'b0, brk_out}, 16'h0);
    for (int i = 0; i < 3; i++) read_chk(2'(i), 8'h00, "R1 reg");

    // R2: register map readback
    set_bp(16'hBEEF);
    set_ctrl(1'b0, 1'b1, 1'b0);
    read_chk(2'd0, 8'hEF, "R2 low byte");
    read_chk(2'd1, 8'hBE, "R2 high byte");
    read_chk(2'd2, 8'h02, "R2 ctrl");
    set_ctrl(1'b0, 1'b0, 1'b0);

    // R4: disabled, matching address gives nothing and no hit
    for (int k = 0; k < 4; k++) step(bp, "R4 disabled");
    step(bp ^ 16'h8000, "R4 disabled");
    read_chk(2'd2, 8'h00, "R7 no hit while disabled");

    // R3: level mode sweep of single-bit neighbours
    for (int b = 0; b < 4; b++) begin
      logic [15:0] v;
      v = (b == 0) ? 16'h0000 : (b == 1) ? 16'hFFFF : (b == 2) ? 16'hA5C3 : 16'h1234;
      cpu_addr = v ^ 16'h8000;
      set_bp(v);
      set_ctrl(1'b1, 1'b0, 1'b1);
      for (int k = 0; k <= 16; k++) begin
        step((k < 16) ? (v ^ (16'h1 << k)) : v, "R3 level");
        step(v ^ 16'h0100, "R3 level");
      end
    end

    // R9: long match in level mode
    for (int k = 0; k < 5; k++) step(bp, "R9 level hold");
    step(bp ^ 16'h0001, "R9 level release");

    // R7: hit set, write 0 keeps, write 1 clears, set wins over clear
    @(negedge clk);
    read_chk(2'd2, 8'h05, "R7 hit set");
    set_ctrl(1'b1, 1'b0, 1'b0);
    read_chk(2'd2, 8'h05, "R7 write 0 keeps");
    set_ctrl(1'b1, 1'b0, 1'b1);
    read_chk(2'd2, 8'h01, "R7 write 1 clears");
    cpu_addr = bp;
    repeat (3) @(negedge clk);
    set_ctrl(1'b1, 1'b0, 1'b1);
    read_chk(2'd2, 8'h05, "R7 set wins over clear");

    // R8: byte write during a match takes effect next cycle
    check("R8 before", {15'b0, brk_out}, 16'h1);
    wr(2'd0, bp[7:0] ^ 8'h01);
    check("R8 after write", {15'b0, brk_out}, 16'h0);
    wr(2'd0, bp[7:0]);
    check("R8 restored", {15'b0, brk_out}, 16'h1);
    cpu_addr = bp ^ 16'h8000;
    repeat (2) @(negedge clk);

    // R5 / R9: pulse mode, match runs of length 1..3
    set_ctrl(1'b1, 1'b1, 1'b1);
    for (int len = 1; len <= 3; len++) begin
      for (int k = 0; k < len; k++) step(bp, (len == 1) ? "R5 pulse" : "R9 pulse hold");
      for (int k = 0; k < 10; k++) step(bp ^ 16'h8000, (len == 1) ? "R5 pulse" : "R9 pulse hold");
    end

    // R6: retrigger at every distance into a running pulse
    for (int gap = 1; gap <= 9; gap++) begin
      step(bp, "R6 retrigger");
      for (int k = 0; k < gap - 1; k++) step(bp ^ 16'h0010, "R6 retrigger");
      step(bp, "R6 retrigger");
      for (int k = 0; k < 10; k++) step(bp ^ 16'h0010, "R6 retrigger");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule